// File: doc/BRIEF.md
# Link Serializer Mode Controller

This block sequences a serial link transmitter through its operating modes. It runs on the transmitter's reference clock and decides, one frame per clock, whether the line carries a sync pattern or a data frame. It also decides whether the line driver is enabled at all. A lock-wait counter stands in for the clock-multiplier lock indication. After reset, and again each time the power-down input is released, the line stays off until that counter has run out.

Two sync request inputs let the far end, or local software, ask for a resynchronization burst. A request counts only after it has persisted for several clocks. Once a request is taken, the block sends a fixed minimum number of sync patterns that cannot be interrupted. The burst runs longer for as long as either request input is still high. The enable input gates the driver directly and leaves all internal timing untouched. The shift datapath, the clock multiplier and the line driver itself sit outside this block.

Top module: `link_mode_ctrl`

## Requirements
- R1: After synchronous reset, `mode_sync`, `frame_valid` and `drv_en` are 0. With `pwrdn_n` high, the line stays off (`drv_en`=0, `frame_valid`=0) until the LOCK_CYCLES-th rising edge after reset release. From that edge on, data mode is active.
- R2: A sync request is taken only when at least one of `sync_req_a`/`sync_req_b` has been sampled high on SYNC_QUAL (6) consecutive edges. Any edge with both inputs low clears the run. `mode_sync` (1 = sync pattern, 0 = data) rises right after the sixth such edge.
- R3: A request that has been taken produces exactly BURST_LEN (1024) consecutive cycles with `mode_sync`=1 when both inputs are low once the burst completes.
- R4: If either request input is high on the edge where the minimum burst would end, `mode_sync` stays 1. It falls after the first edge on which both inputs are sampled low.
- R5: Request activity during a running burst neither shortens nor restarts the minimum burst count.
- R6: `frame_valid` is 0 in every cycle in which `mode_sync` is 1.
- R7: In data mode, `frame_valid` is 1 after an edge exactly when both request inputs were sampled low on that edge.
- R8: While `pwrdn_n` is low, `drv_en` is 0 at once, without waiting for a clock edge. After the next edge, `mode_sync` and `frame_valid` are 0. Releasing `pwrdn_n` forces a full new LOCK_CYCLES wait before the line turns on.
- R9: `line_en` gates `drv_en` without waiting for a clock edge once lock is reached. It has no effect on `mode_sync`, `frame_valid` or burst timing.
- R10: Request cycles that occur during the lock wait do not count toward the six-cycle qualification. A request held high across lock completion is taken on the sixth edge after lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_req_a | input | 1 | Sync request input A |
| sync_req_b | input | 1 | Sync request input B |
| pwrdn_n | input | 1 | Power-down, active low |
| line_en | input | 1 | Line driver enable request |
| mode_sync | output | 1 | 1 = send sync pattern, 0 = send data |
| frame_valid | output | 1 | A data frame is sent this cycle |
| drv_en | output | 1 | Line driver output enable |

## Verification
The hardest situations to reach are the timing edges of the burst. One is a request that stays high past the minimum burst end. Another is request activity that lands in the burst's last cycle. A third is a request held high across lock completion, or dropped in the middle of a burst by power-down. The bench drives request inputs from per-edge bit patterns, sweeping request lengths on both inputs from one clock up to well past the burst end. It then replays hand-picked patterns: handoff between inputs, interrupted runs, and late toggles. It uses a small lock and burst configuration and compares each cycle against a model of the requirements.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

    typedef enum logic [1:0] {
        LM_LOCK = 2'd0,
        LM_DATA = 2'd1,
        LM_SYNC = 2'd2
    } lmc_mode_e;

    typedef struct packed {
        logic mode_sync;
        logic frame_valid;
    } lmc_out_t;

    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lmc_lock_timer.sv
module lmc_lock_timer
    import lmc_pkg::*;
#(
    parameter int LOCK_CYCLES = 2049
) (
    input  logic clk,
    input  logic rst,
    input  logic pwrdn_n,
    output logic lock_hit
);
    localparam int CW = cnt_bits(LOCK_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          lock_ok;

    assign lock_hit = pwrdn_n && !lock_ok && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !pwrdn_n) begin
            cnt     <= '0;
            lock_ok <= 1'b0;
        end else if (!lock_ok) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) lock_ok <= 1'b1;
        end
    end

    assert_lock_cleared_R1: assert property (@(posedge clk) disable iff (rst)
        !pwrdn_n |=> !lock_ok);

endmodule

// File: rtl/lmc_sync_qual.sv
module lmc_sync_qual
    import lmc_pkg::*;
#(
    parameter int SYNC_QUAL = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic req_a,
    input  logic req_b,
    output logic any_req,
    output logic accept
);
    localparam int QW = cnt_bits(SYNC_QUAL);
    localparam logic [QW-1:0] QMAX = QW'(SYNC_QUAL);
    localparam logic [QW-1:0] QPRE = QW'(SYNC_QUAL - 1);

    logic [QW-1:0] run;

    assign any_req = req_a | req_b;
    assign accept  = arm && any_req && (run == QPRE);

    always_ff @(posedge clk) begin
        if (rst || !arm || !any_req) run <= '0;
        else if (run != QMAX)        run <= run + 1'b1;
    end

    assert_qual_cleared_R2: assert property (@(posedge clk) disable iff (rst)
        (arm && !any_req) |=> (run == '0));

endmodule

// File: rtl/lmc_burst_ctr.sv
module lmc_burst_ctr
    import lmc_pkg::*;
#(
    parameter int BURST_LEN = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic last
);
    localparam int BW = cnt_bits(BURST_LEN);
    localparam logic [BW-1:0] FULL = BW'(BURST_LEN);

    logic [BW-1:0] rem;

    assign last = (rem <= BW'(1));

    always_ff @(posedge clk) begin
        if (rst)                      rem <= '0;
        else if (load)                rem <= FULL;
        else if (run && rem != '0)    rem <= rem - 1'b1;
    end

    assert_load_full_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (rem == FULL));

endmodule

// File: rtl/link_mode_ctrl.sv
module link_mode_ctrl
    import lmc_pkg::*;
#(
    parameter int LOCK_CYCLES = 2049,
    parameter int SYNC_QUAL   = 6,
    parameter int BURST_LEN   = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_req_a,
    input  logic sync_req_b,
    input  logic pwrdn_n,
    input  logic line_en,
    output logic mode_sync,
    output logic frame_valid,
    output logic drv_en
);
    lmc_mode_e state, nxt;
    lmc_out_t  outs;
    logic      lock_hit, any_req, accept, burst_last, arm, load;

    assign arm  = (state != LM_LOCK) && pwrdn_n;
    assign load = (state == LM_DATA) && accept;

    lmc_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk(clk), .rst(rst), .pwrdn_n(pwrdn_n), .lock_hit(lock_hit)
    );

    lmc_sync_qual #(.SYNC_QUAL(SYNC_QUAL)) u_qual (
        .clk(clk), .rst(rst), .arm(arm), .req_a(sync_req_a), .req_b(sync_req_b),
        .any_req(any_req), .accept(accept)
    );

    lmc_burst_ctr #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk(clk), .rst(rst), .load(load), .run(state == LM_SYNC), .last(burst_last)
    );

    always_comb begin
        nxt = state;
        case (state)
            LM_LOCK: if (lock_hit) nxt = LM_DATA;
            LM_DATA: if (accept) nxt = LM_SYNC;
            LM_SYNC: if (burst_last && !any_req) nxt = LM_DATA;
            default: nxt = LM_LOCK;
        endcase
        if (!pwrdn_n) nxt = LM_LOCK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state            <= LM_LOCK;
            outs.frame_valid <= 1'b0;
        end else begin
            state            <= nxt;
            outs.frame_valid <= (nxt == LM_DATA) && !any_req;
        end
    end

    assign outs.mode_sync = (state == LM_SYNC);
    assign mode_sync      = outs.mode_sync;
    assign frame_valid    = outs.frame_valid;
    assign drv_en         = (state != LM_LOCK) && pwrdn_n && line_en;

    assert_take_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_sync) |-> $past(any_req));

    assert_min_burst_R3: assert property (@(posedge clk) disable iff (rst)
        (state == LM_SYNC && !burst_last && pwrdn_n) |=> (state == LM_SYNC));

    assert_extend_R4: assert property (@(posedge clk) disable iff (rst)
        (state == LM_SYNC && any_req && pwrdn_n) |=> (state == LM_SYNC));

    assert_no_frame_in_sync_R6: assert property (@(posedge clk) disable iff (rst)
        mode_sync |-> !frame_valid);

    assert_frame_needs_idle_R7: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> $past(!any_req));

    assert_pd_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !pwrdn_n |=> (state == LM_LOCK && !frame_valid));

endmodule

// File: tb/link_mode_ctrl_tb.sv
module link_mode_ctrl_tb;
    localparam int LOCK_T  = 12;
    localparam int QUAL_T  = 6;
    localparam int BURST_T = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_req_a = 1'b0, sync_req_b = 1'b0;
    logic pwrdn_n = 1'b1, line_en = 1'b1;
    logic mode_sync, frame_valid, drv_en;
    int   n_cmp = 0, n_bad = 0;

    link_mode_ctrl #(.LOCK_CYCLES(LOCK_T), .SYNC_QUAL(QUAL_T), .BURST_LEN(BURST_T)) u_dut (
        .clk(clk), .rst(rst), .sync_req_a(sync_req_a), .sync_req_b(sync_req_b),
        .pwrdn_n(pwrdn_n), .line_en(line_en),
        .mode_sync(mode_sync), .frame_valid(frame_valid), .drv_en(drv_en)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: got %b expected %b", tag, what, $time, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drive request/enable patterns, bit k applies to edge k; compare per cycle.
    task automatic run_pat(input logic [63:0] pa, input logic [63:0] pb,
                           input logic [63:0] pe, input int ncyc, input string tag);
        int  run = 0;
        int  s = 0;
        logic insync = 1'b0;
        logic req;
        sync_req_a = pa[1]; sync_req_b = pb[1]; line_en = pe[1];
        #1 chk("R9", "drv_en", drv_en, pe[1]);
        for (int k = 1; k <= ncyc; k++) begin
            step();
            req = pa[k] | pb[k];
            if (!insync) begin
                run = req ? run + 1 : 0;
                if (run >= QUAL_T) begin insync = 1'b1; s = k; end
            end else if (k >= s + BURST_T && !req) begin
                insync = 1'b0; run = 0;
            end
            chk(tag, "mode_sync", mode_sync, insync);
            chk(insync ? "R6" : "R7", "frame_valid", frame_valid, !insync && !req);
            sync_req_a = (k < 63) ? pa[k+1] : 1'b0;
            sync_req_b = (k < 63) ? pb[k+1] : 1'b0;
            line_en    = (k < 63) ? pe[k+1] : 1'b1;
            #1 chk("R9", "drv_en", drv_en, line_en);
        end
        sync_req_a = 1'b0; sync_req_b = 1'b0; line_en = 1'b1;
        repeat (3) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: got hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] ones = '1;
        repeat (3) step();
        chk("R1", "reset mode_sync", mode_sync, 1'b0);
        chk("R1", "reset frame_valid", frame_valid, 1'b0);
        chk("R1", "reset drv_en", drv_en, 1'b0);
        rst = 1'b0;
        for (int k = 1; k <= LOCK_T + 3; k++) begin
            step();
            chk("R1", "lock drv_en", drv_en, k >= LOCK_T);
            chk("R1", "lock frame_valid", frame_valid, k >= LOCK_T);
            chk("R1", "lock mode_sync", mode_sync, 1'b0);
        end

        // Request length sweep on alternating inputs
        for (int len = 1; len <= 9; len++) begin
            logic [63:0] m = (64'd1 << (len + 1)) - 64'd2;
            if (len % 2 == 1) run_pat('0, m, ones, 40, (len < QUAL_T) ? "R2" : "R3");
            else              run_pat(m, '0, ones, 40, (len < QUAL_T) ? "R2" : "R3");
        end
        run_pat((64'd1 << 21) - 64'd2, '0, ones, 40, "R4");
        run_pat('0, (64'd1 << 31) - 64'd2, ones, 40, "R4");
        run_pat(64'h0E, 64'h70, ones, 40, "R2");       // handoff between inputs
        run_pat(64'hEE, '0, ones, 40, "R2");           // interrupted run
        run_pat(64'h1807E, 64'h1E00, ones, 40, "R5");  // toggles inside burst
        run_pat(64'h7E, 64'h200400, ones, 40, "R5");   // toggle in last burst cycle
        run_pat(64'h7E, '0, ~64'h1F00, 40, "R9");      // enable dropped mid burst
        run_pat('0, 64'h7E, ~64'h6, 40, "R9");         // enable dropped before take

        // Power-down from data mode, request held across the new lock wait
        pwrdn_n = 1'b0;
        #1 chk("R8", "drv_en async", drv_en, 1'b0);
        step();
        chk("R8", "pd frame_valid", frame_valid, 1'b0);
        chk("R8", "pd mode_sync", mode_sync, 1'b0);
        sync_req_a = 1'b1;
        step();
        pwrdn_n = 1'b1;
        for (int k = 1; k <= LOCK_T + 8; k++) begin
            step();
            chk("R8", "relock drv_en", drv_en, k >= LOCK_T);
            chk("R10", "relock mode_sync", mode_sync, k >= LOCK_T + QUAL_T);
            chk("R7", "relock frame_valid", frame_valid, 1'b0);
        end
        sync_req_a = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R3", "burst mode_sync", mode_sync, 1'b1);
        end
        pwrdn_n = 1'b0;
        #1 chk("R8", "drv_en async in burst", drv_en, 1'b0);
        step();
        chk("R8", "pd burst mode_sync", mode_sync, 1'b0);
        chk("R8", "pd burst frame_valid", frame_valid, 1'b0);
        step();
        pwrdn_n = 1'b1;
        for (int k = 1; k <= LOCK_T + 2; k++) begin
            step();
            chk("R8", "relock2 drv_en", drv_en, k >= LOCK_T);
            chk("R8", "relock2 frame_valid", frame_valid, k >= LOCK_T);
            chk("R8", "relock2 mode_sync", mode_sync, 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule